// File: doc/BRIEF.md
# Renamed Descriptor Binding Pool

This block lets several versions of a resource binding table exist at once while storing their entries in one shared pool of physical descriptor slots. A logical binding slot in a version is only a pointer into the pool. When a version is opened, it inherits every pointer of the version before it, so an unchanged binding costs no new storage. Writing a slot takes a fresh physical entry from a free list and repoints that slot in the newest version only. The descriptor data itself lives in a table outside the block, which is written at the index the block hands out.

Versions form a ring. New ones are opened at the head and the oldest is retired at the tail once the work using it has finished. A physical entry goes back to the free list when it is held but no live version points at it any more. Returned entries rejoin the list one per cycle, lowest index first. Small workloads bind few slots, so the pool leaves room for many versions. A workload that binds close to the whole logical table quickly runs the pool dry, and new binds then wait until old versions retire.

A lookup port turns a (version, logical slot) pair into a physical index, registered, one cycle later.

Top module: `desc_rename_pool`

## Requirements
- R1: After reset every physical entry is free, one version (ring index 0) is live with no bindings, `bind_ready` and `open_ready` are 1, `retire_ready` is 0, and every lookup misses.
- R2: After reset the free list hands out physical indices in ascending order 0, 1, 2, …. `alloc_idx` shows the index a bind in that cycle takes, and that index is recorded for the bound slot in the current (head) version.
- R3: A bind never receives a physical index that any live version still points at.
- R4: `bind_ready` is 0 while the free list is empty. Once returns have settled, the number of binds accepted before a stall equals the pool size minus the number of distinct entries referenced by live versions.
- R5: Opening a version advances the head by one (modulo NVER, a power of two) and copies every binding of the previous head. Later binds in the new version leave the lookups of older versions unchanged.
- R6: Rebinding a slot releases its previous entry once no other live version refers to it, and that entry becomes available to later binds.
- R7: Retiring removes the oldest live version. Its lookups then miss, and entries referenced only by it return to the pool. `retire_ready` is 0 while a single version is live.
- R8: `open_ready` is 0 while NVER versions are live, and `bind_ready` is 0 in any cycle where `open_valid` is 1 (open takes precedence).
- R9: A lookup presented before a clock edge gives `lk_hit` and `lk_idx` after that edge. A miss gives `lk_hit` = 0 and `lk_idx` = 0.
- R10: A bind into the head and a retire of the tail in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bind_valid | input | 1 | Request to bind a slot in the head version |
| bind_slot | input | LW | Logical slot to bind |
| bind_ready | output | 1 | Bind accepted this cycle when high with bind_valid |
| alloc_idx | output | PW | Physical index taken by the bind |
| open_valid | input | 1 | Request to open a new head version |
| open_ready | output | 1 | Ring has room for another version |
| retire_valid | input | 1 | Request to retire the oldest version |
| retire_ready | output | 1 | More than one version is live |
| lk_ver | input | VW | Ring index of the version to look up |
| lk_slot | input | LW | Logical slot to look up |
| lk_hit | output | 1 | Slot is bound in that version (registered) |
| lk_idx | output | PW | Physical index of the binding (registered) |

## Verification
Two things can happen to the reference state in one cycle: a bind repoints a slot in the head, and a retire drops every pointer of the tail. The bench provokes this by letting the ring wrap down to one live version, opening a new head at ring index 0, and then raising bind and retire together. It requires both to be accepted. A full sweep of lookups must then show the retired version missing everywhere and the head carrying the new binding. A later fill must count exactly the free entries that its model predicts.

// File: rtl/desc_rename_pool.sv
module desc_rename_pool #(
  parameter int NPHYS = 128,
  parameter int NLOG  = 128,
  parameter int NVER  = 4,
  localparam int PW   = (NPHYS > 1) ? $clog2(NPHYS) : 1,
  localparam int LW   = (NLOG > 1) ? $clog2(NLOG) : 1,
  localparam int VW   = $clog2(NVER),
  localparam int CW   = $clog2(NPHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bind_valid,
  input  logic [LW-1:0] bind_slot,
  output logic          bind_ready,
  output logic [PW-1:0] alloc_idx,
  input  logic          open_valid,
  output logic          open_ready,
  input  logic          retire_valid,
  output logic          retire_ready,
  input  logic [VW-1:0] lk_ver,
  input  logic [LW-1:0] lk_slot,
  output logic          lk_hit,
  output logic [PW-1:0] lk_idx
);

  logic [PW-1:0]    map_idx [NVER][NLOG];
  logic [NLOG-1:0]  map_vld [NVER];
  logic [NPHYS-1:0] refs    [NVER];
  logic [PW-1:0]    fifo    [NPHYS];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    fcnt;
  logic [NPHYS-1:0] held, inuse, cand;
  logic [NPHYS-1:0] new_mask, old_mask, rec_mask;
  logic [VW-1:0]    head, tail, nxt_head;
  logic [VW:0]      nlive;
  logic [NVER-1:0]  live;
  logic             rec_any;
  logic [PW-1:0]    rec_idx;
  logic             open_fire, bind_fire, ret_fire;
  logic             old_vld;
  logic [PW-1:0]    old_idx;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(NPHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nxt_head     = head + 1'b1;
  assign open_ready   = nlive != (VW+1)'(NVER);
  assign retire_ready = nlive > (VW+1)'(1);
  assign bind_ready   = (fcnt != '0) && !open_valid;
  assign alloc_idx    = fifo[rd_ptr];

  assign open_fire = open_valid && open_ready;
  assign bind_fire = bind_valid && bind_ready;
  assign ret_fire  = retire_valid && retire_ready;

  assign old_vld = map_vld[head][bind_slot];
  assign old_idx = map_idx[head][bind_slot];

  assign new_mask = bind_fire ? (NPHYS'(1) << alloc_idx) : '0;
  assign old_mask = (bind_fire && old_vld) ? (NPHYS'(1) << old_idx) : '0;
  assign rec_mask = rec_any ? (NPHYS'(1) << rec_idx) : '0;

  always_comb begin
    for (int v = 0; v < NVER; v++)
      live[v] = {1'b0, VW'(VW'(v) - tail)} < nlive;
  end

  always_comb begin
    inuse = '0;
    for (int v = 0; v < NVER; v++)
      if (live[v]) inuse = inuse | refs[v];
  end

  assign cand    = held & ~inuse;
  assign rec_any = |cand;

  always_comb begin
    rec_idx = '0;
    for (int p = NPHYS - 1; p >= 0; p--)
      if (cand[p]) rec_idx = PW'(p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) fifo[i] <= PW'(i);
      for (int v = 0; v < NVER; v++) begin
        map_vld[v] <= '0;
        refs[v]    <= '0;
      end
      held   <= '0;
      head   <= '0;
      tail   <= '0;
      nlive  <= (VW+1)'(1);
      rd_ptr <= '0;
      wr_ptr <= '0;
      fcnt   <= CW'(NPHYS);
    end else begin
      if (open_fire) begin
        map_vld[nxt_head] <= map_vld[head];
        refs[nxt_head]    <= refs[head];
        head              <= nxt_head;
      end
      if (bind_fire) begin
        map_vld[head][bind_slot] <= 1'b1;
        refs[head]               <= (refs[head] & ~old_mask) | new_mask;
        rd_ptr                   <= wrap_inc(rd_ptr);
      end
      if (ret_fire) begin
        map_vld[tail] <= '0;
        refs[tail]    <= '0;
        tail          <= tail + 1'b1;
      end
      if (rec_any) begin
        fifo[wr_ptr] <= rec_idx;
        wr_ptr       <= wrap_inc(wr_ptr);
      end
      held  <= (held | new_mask) & ~rec_mask;
      fcnt  <= fcnt + CW'(rec_any) - CW'(bind_fire);
      nlive <= nlive + (VW+1)'(open_fire) - (VW+1)'(ret_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (open_fire)
      for (int s = 0; s < NLOG; s++) map_idx[nxt_head][s] <= map_idx[head][s];
    if (bind_fire)
      map_idx[head][bind_slot] <= alloc_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_idx <= '0;
    end else begin
      lk_hit <= map_vld[lk_ver][lk_slot];
      lk_idx <= map_vld[lk_ver][lk_slot] ? map_idx[lk_ver][lk_slot] : '0;
    end
  end

endmodule

module desc_rename_pool_chk #(
  parameter int NPHYS = 128,
  parameter int NVER  = 4,
  localparam int PW   = (NPHYS > 1) ? $clog2(NPHYS) : 1,
  localparam int VW   = $clog2(NVER),
  localparam int CW   = $clog2(NPHYS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bind_valid,
  input logic             bind_ready,
  input logic [PW-1:0]    alloc_idx,
  input logic             open_valid,
  input logic             open_ready,
  input logic             retire_valid,
  input logic             retire_ready,
  input logic [CW-1:0]    fcnt,
  input logic [NPHYS-1:0] held,
  input logic [VW:0]      nlive
);

  p_pool_conserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fcnt) + $countones(held) == NPHYS);

  p_stall_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt == '0 |-> !bind_ready);

  p_fresh_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bind_valid && bind_ready |-> !held[alloc_idx]);

  p_live_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nlive >= (VW+1)'(1) && nlive <= (VW+1)'(NVER));

  p_version_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_valid && open_ready && !(retire_valid && retire_ready)
    |=> nlive == $past(nlive) + 1'b1);

  p_retire_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nlive == (VW+1)'(1) |-> !retire_ready);

endmodule

bind desc_rename_pool desc_rename_pool_chk #(.NPHYS(NPHYS), .NVER(NVER)) u_chk (
  .clk(clk), .rst_n(rst_n), .bind_valid(bind_valid), .bind_ready(bind_ready),
  .alloc_idx(alloc_idx), .open_valid(open_valid), .open_ready(open_ready),
  .retire_valid(retire_valid), .retire_ready(retire_ready),
  .fcnt(fcnt), .held(held), .nlive(nlive)
);

// File: tb/desc_rename_pool_bench.sv
`timescale 1ns/1ps
module desc_rename_pool_bench;
  localparam int NP = 8, NL = 16, NV = 4;
  localparam int PW = 3, LW = 4, VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          bind_valid = 1'b0, open_valid = 1'b0, retire_valid = 1'b0;
  logic [LW-1:0] bind_slot = '0, lk_slot = '0;
  logic [VW-1:0] lk_ver = '0;
  logic          bind_ready, open_ready, retire_ready, lk_hit;
  logic [PW-1:0] alloc_idx, lk_idx;

  desc_rename_pool #(.NPHYS(NP), .NLOG(NL), .NVER(NV)) u_desc_rename_pool (
    .clk(clk), .rst_n(rst_n),
    .bind_valid(bind_valid), .bind_slot(bind_slot), .bind_ready(bind_ready), .alloc_idx(alloc_idx),
    .open_valid(open_valid), .open_ready(open_ready),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .lk_ver(lk_ver), .lk_slot(lk_slot), .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

  int n_cmp = 0, n_bad = 0;
  int mm [NV][NL];
  int mh, mt, mn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_live(input int v);
    return ((v - mt + NV) % NV) < mn;
  endfunction

  function automatic bit used(input int p);
    for (int v = 0; v < NV; v++)
      if (is_live(v))
        for (int s = 0; s < NL; s++)
          if (mm[v][s] == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int used_cnt();
    int c = 0;
    for (int p = 0; p < NP; p++) if (used(p)) c++;
    return c;
  endfunction

  task automatic cyc(input bit bv, input int bs, input bit ov, input bit rv,
                     output bit bf, output int ai, output bit of, output bit rf);
    @(negedge clk);
    bind_valid = bv; bind_slot = LW'(bs); open_valid = ov; retire_valid = rv;
    #1;
    bf = bv && bind_ready;
    ai = int'(alloc_idx);
    of = ov && open_ready;
    rf = rv && retire_ready;
    @(posedge clk);
    #1;
    bind_valid = 1'b0; open_valid = 1'b0; retire_valid = 1'b0;
    if (of) begin
      for (int s = 0; s < NL; s++) mm[(mh + 1) % NV][s] = mm[mh][s];
      mh = (mh + 1) % NV;
      mn++;
    end
    if (bf) begin
      chk(!used(ai), "R3 fresh index", ai, -1);
      mm[mh][bs] = ai;
    end
    if (rf) begin
      for (int s = 0; s < NL; s++) mm[mt][s] = -1;
      mt = (mt + 1) % NV;
      mn--;
    end
  endtask

  task automatic look(input int v, input int s, output bit h, output int i);
    @(negedge clk);
    lk_ver = VW'(v); lk_slot = LW'(s);
    @(posedge clk);
    #1;
    h = lk_hit;
    i = int'(lk_idx);
  endtask

  task automatic sweep(input string req);
    bit h; int i; bit eh;
    for (int v = 0; v < NV; v++)
      for (int s = 0; s < NL; s++) begin
        look(v, s, h, i);
        eh = is_live(v) && mm[v][s] >= 0;
        chk(h == eh, {req, " R9 hit"}, h, eh);
        chk(i == (eh ? mm[v][s] : 0), {req, " R9 index"}, i, eh ? mm[v][s] : 0);
      end
  endtask

  task automatic settle();
    repeat (NP + 2) @(posedge clk);
  endtask

  task automatic fill(input string req);
    bit bf, of, rf; int ai; int exp_n; int got;
    settle();
    exp_n = NP - used_cnt();
    got = 0;
    for (int s = 0; s < NL; s++)
      if (mm[mh][s] < 0) begin
        cyc(1'b1, s, 1'b0, 1'b0, bf, ai, of, rf);
        if (!bf) break;
        got++;
      end
    chk(got == exp_n, {req, " accepted binds before stall"}, got, exp_n);
  endtask

  initial begin
    bit bf, of, rf; int ai;
    for (int v = 0; v < NV; v++)
      for (int s = 0; s < NL; s++) mm[v][s] = -1;
    mh = 0; mt = 0; mn = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(bind_ready == 1'b1, "R1 bind_ready", bind_ready, 1);
    chk(open_ready == 1'b1, "R1 open_ready", open_ready, 1);
    chk(retire_ready == 1'b0, "R1 retire_ready", retire_ready, 0);
    sweep("R1");

    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, k, 1'b0, 1'b0, bf, ai, of, rf);
      chk(bf, "R2 bind accepted", bf, 1);
      chk(ai == k, "R2 ascending index", ai, k);
    end
    sweep("R2");

    cyc(1'b1, 7, 1'b1, 1'b0, bf, ai, of, rf);
    chk(!bf, "R8 bind blocked by open", bf, 0);
    chk(of, "R5 open accepted", of, 1);
    sweep("R5");
    cyc(1'b1, 1, 1'b0, 1'b0, bf, ai, of, rf);
    chk(bf && ai == 4, "R2 next index", ai, 4);
    sweep("R5");

    cyc(1'b1, 1, 1'b0, 1'b0, bf, ai, of, rf);
    chk(bf && ai == 5, "R6 rebind index", ai, 5);
    fill("R4");
    chk(used(4), "R6 released entry reissued", used(4), 1);
    chk(bind_ready == 1'b0, "R4 ready low when empty", bind_ready, 0);

    cyc(1'b0, 0, 1'b1, 1'b0, bf, ai, of, rf);
    chk(of, "R5 open", of, 1);
    cyc(1'b0, 0, 1'b1, 1'b0, bf, ai, of, rf);
    chk(of, "R5 open", of, 1);
    cyc(1'b0, 0, 1'b1, 1'b0, bf, ai, of, rf);
    chk(!of, "R8 open refused when full", of, 0);
    sweep("R5");

    cyc(1'b0, 0, 1'b0, 1'b1, bf, ai, of, rf);
    chk(rf, "R7 retire accepted", rf, 1);
    settle();
    sweep("R7");
    chk(!used(1), "R7 entry of retired version unused", used(1), 0);
    cyc(1'b0, 0, 1'b0, 1'b1, bf, ai, of, rf);
    chk(rf, "R7 retire", rf, 1);
    cyc(1'b0, 0, 1'b0, 1'b1, bf, ai, of, rf);
    chk(rf, "R7 retire", rf, 1);
    cyc(1'b0, 0, 1'b0, 1'b1, bf, ai, of, rf);
    chk(!rf, "R7 last version kept", rf, 0);
    sweep("R7");

    cyc(1'b0, 0, 1'b1, 1'b0, bf, ai, of, rf);
    chk(of, "R5 open wraps to ring 0", of, 1);
    settle();
    cyc(1'b1, 15, 1'b0, 1'b1, bf, ai, of, rf);
    chk(bf, "R10 bind with retire", bf, 1);
    chk(rf, "R10 retire with bind", rf, 1);
    sweep("R10");

    fill("R4");
    sweep("R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule